// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Atomic Settings Commit

This block drives four independent pulse-width modulated outputs. Each channel is programmed through a small memory-mapped register window with three words: a period length, a high-time length and a control word that picks a clock prescale and an output inversion. Both lengths count in units of a prescaled microsecond tick. The microsecond tick arrives as a one-cycle enable pulse on `tick_1us`.

Software writes never disturb a running waveform half-way. Every write lands in a shadow copy. A write to the period word arms a commit. The armed values then move into the active set together at the end of the period that is running, so one period always uses one consistent set of settings. A period value of zero stops the channel once the current period has run out, and the output then stays low. An idle channel with an armed commit takes the new settings straight away and starts counting from zero.

The register port accepts one access per cycle and never stalls. A write is taken in any cycle where `bus_wr` is high. A read is combinational from `bus_addr`. There is no data stream in this block, so the port needs no valid/ready handshake and has no back-pressure.

Top module: `pwm_shadow_bank`

## Requirements
- R1: After reset every shadow and active value is zero, nothing is armed and all four outputs are low.
- R2: The period word of channel c sits at byte offset 0x400+4c and the high-time word at 0x420+4c, each holding CNT_W bits in bits [CNT_W-1:0]. The control word sits at 0x440+4c with the prescale select in bits [1:0] and inversion in bit 5. Reads return the last written shadow value, and all other control bits read as zero.
- R3: Unaligned offsets, channel numbers of 4 and above, and offsets outside the three word groups read as zero, and writes to them change neither readback nor outputs.
- R4: With active period P>0, high time D and prescale S, one period lasts P·2^S ticks. A non-inverted output is high for the first D·2^S ticks and low for the rest. D≥P gives a constant high level.
- R5: With inversion set, a running channel outputs the complement of the R4 waveform.
- R6: Writes to high time or control, without a later period write, never change the output.
- R7: A period write arms a commit. The tick that ends the running period loads shadow period, high time, prescale and inversion together, and the next period starts from zero with them.
- R8: Committing a period of zero makes the output low from then on, whatever the inversion bit.
- R9: A stopped channel with an armed commit loads the shadows in the cycle after the period write. The first period of the new settings starts in the cycle after that.
- R10: Counting advances only in cycles where `tick_1us` is high. Without ticks the output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1us | input | 1 | One-cycle microsecond tick enable |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The bench builds the block with NUM_CH=4 and CNT_W=8. The narrow counter lets short periods with all four prescale settings cycle many times within the run. It also makes the truncation of wide write data easy to see on readback. Random writes land on random channels and random prescales while the tick enable is sparse, dense or held off. This drives commits at every phase of a running period, back-to-back arming, stops with inversion set, and restarts from the idle state.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned REG_AW = 12;
  // word group selectors, taken from bus_addr[11:5]
  localparam logic [6:0] GRP_PERIOD = 7'h20;
  localparam logic [6:0] GRP_HIGH   = 7'h21;
  localparam logic [6:0] GRP_CTRL   = 7'h22;
  localparam int unsigned CTRL_INV_BIT = 5;

  typedef enum logic [1:0] {
    FLD_NONE   = 2'd0,
    FLD_PERIOD = 2'd1,
    FLD_HIGH   = 2'd2,
    FLD_CTRL   = 2'd3
  } fld_e;
endpackage

// File: rtl/pwm_regdecode.sv
module pwm_regdecode
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  output fld_e              acc_fld,
  output logic [2:0]        acc_ch,
  output logic [NUM_CH-1:0] wr_period,
  output logic [NUM_CH-1:0] wr_high,
  output logic [NUM_CH-1:0] wr_ctrl
);
  logic ch_ok;

  assign acc_ch = bus_addr[4:2];
  assign ch_ok  = (bus_addr[1:0] == 2'b00) && (int'(acc_ch) < NUM_CH);

  always_comb begin
    acc_fld = FLD_NONE;
    if (ch_ok) begin
      case (bus_addr[11:5])
        GRP_PERIOD: acc_fld = FLD_PERIOD;
        GRP_HIGH:   acc_fld = FLD_HIGH;
        GRP_CTRL:   acc_fld = FLD_CTRL;
        default:    acc_fld = FLD_NONE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
    logic hit;
    assign hit          = bus_wr && (acc_ch == 3'(i));
    assign wr_period[i] = hit && (acc_fld == FLD_PERIOD);
    assign wr_high[i]   = hit && (acc_fld == FLD_HIGH);
    assign wr_ctrl[i]   = hit && (acc_fld == FLD_CTRL);
  end

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0({wr_period, wr_high, wr_ctrl})); // R3
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             stick
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] wrap_at;

  assign wrap_at = (PRE_W'(1) << sel) - PRE_W'(1);
  assign stick   = tick && (pre_q == wrap_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (restart)  pre_q <= '0;
    else if (stick)    pre_q <= '0;
    else if (tick)     pre_q <= pre_q + PRE_W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= wrap_at); // R4
  AST_PRE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(pre_q)); // R10
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_period,
  input  logic             wr_high,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wdata,
  input  logic [SEL_W-1:0] wsel,
  input  logic             winv,
  output logic [CNT_W-1:0] sh_period,
  output logic [CNT_W-1:0] sh_high,
  output logic [SEL_W-1:0] sh_sel,
  output logic             sh_inv,
  output logic             pwm
);
  logic             armed;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] act_high;
  logic [SEL_W-1:0] act_sel;
  logic             act_inv;
  logic [CNT_W-1:0] cnt_q;
  logic             running;
  logic             stick;
  logic             last;
  logic             commit;

  assign running = (act_period != '0);
  assign last    = stick && running && (cnt_q == act_period - CNT_W'(1));
  assign commit  = armed && (!running || last);

  pwm_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (commit),
    .sel     (act_sel),
    .stick   (stick)
  );

  // shadow copies, written by software at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period <= '0;
      sh_high   <= '0;
      sh_sel    <= '0;
      sh_inv    <= 1'b0;
    end else begin
      if (wr_period) sh_period <= wdata;
      if (wr_high)   sh_high   <= wdata;
      if (wr_ctrl) begin
        sh_sel <= wsel;
        sh_inv <= winv;
      end
    end
  end

  // commit arming: a period write always re-arms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed <= 1'b0;
    else if (wr_period) armed <= 1'b1;
    else if (commit)    armed <= 1'b0;
  end

  // active set, loaded only at a commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period <= '0;
      act_high   <= '0;
      act_sel    <= '0;
      act_inv    <= 1'b0;
    end else if (commit) begin
      act_period <= sh_period;
      act_high   <= sh_high;
      act_sel    <= sh_sel;
      act_inv    <= sh_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (commit || last)    cnt_q <= '0;
    else if (stick && running)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign pwm = running && ((cnt_q < act_high) ^ act_inv);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < act_period)); // R4
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_period) && $stable(act_high) &&
                 $stable(act_sel) && $stable(act_inv))); // R6
  AST_COMMIT_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_period == $past(sh_period) && act_high == $past(sh_high) &&
                act_sel == $past(sh_sel) && act_inv == $past(sh_inv))); // R7
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_period) |=> !armed); // R7
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sh_period == '0) |=> !pwm); // R8
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !commit) |=> ($stable(cnt_q) && $stable(pwm))); // R10
endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  fld_e              acc_fld;
  logic [2:0]        acc_ch;
  logic [NUM_CH-1:0] wr_period;
  logic [NUM_CH-1:0] wr_high;
  logic [NUM_CH-1:0] wr_ctrl;
  logic [CNT_W-1:0]  sh_period [NUM_CH];
  logic [CNT_W-1:0]  sh_high   [NUM_CH];
  logic [SEL_W-1:0]  sh_sel    [NUM_CH];
  logic              sh_inv    [NUM_CH];
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CNT_W];

  pwm_regdecode #(.NUM_CH(NUM_CH)) u_dec (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .acc_fld   (acc_fld),
    .acc_ch    (acc_ch),
    .wr_period (wr_period),
    .wr_high   (wr_high),
    .wr_ctrl   (wr_ctrl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_1us),
      .wr_period (wr_period[c]),
      .wr_high   (wr_high[c]),
      .wr_ctrl   (wr_ctrl[c]),
      .wdata     (bus_wdata[CNT_W-1:0]),
      .wsel      (bus_wdata[SEL_W-1:0]),
      .winv      (bus_wdata[CTRL_INV_BIT]),
      .sh_period (sh_period[c]),
      .sh_high   (sh_high[c]),
      .sh_sel    (sh_sel[c]),
      .sh_inv    (sh_inv[c]),
      .pwm       (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (acc_ch == 3'(i)) begin
        case (acc_fld)
          FLD_PERIOD: bus_rdata = DATA_W'(sh_period[i]);
          FLD_HIGH:   bus_rdata = DATA_W'(sh_high[i]);
          FLD_CTRL: begin
            bus_rdata[SEL_W-1:0]    = sh_sel[i];
            bus_rdata[CTRL_INV_BIT] = sh_inv[i];
          end
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_out == '0)); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fld == FLD_NONE) |-> (bus_rdata == '0)); // R3
endmodule

// File: tb/tb_pwm_shadow_bank.sv
module tb_pwm_shadow_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 4;
  localparam int CW   = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1us = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int tick_mode = 0;   // 0 always, 1 random, 2 never
  string cur_req = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shadow_bank #(.NUM_CH(NCH), .CNT_W(CW), .SEL_W(2), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // behavioural reference, counted in raw ticks since period start
  int m_sp[NCH], m_sd[NCH], m_ss[NCH], m_si[NCH], m_arm[NCH];
  int m_ap[NCH], m_ad[NCH], m_as[NCH], m_ai[NCH], m_pos[NCH];

  function automatic int dec_fld(input logic [11:0] a, output int ch);
    ch = int'(a[4:2]);
    if (a[1:0] != 2'b00 || ch >= NCH) return 0;
    case (a[11:5])
      7'h20: return 1;
      7'h21: return 2;
      7'h22: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int ch, f;
    f = dec_fld(a, ch);
    case (f)
      1: return 32'(m_sp[ch]);
      2: return 32'(m_sd[ch]);
      3: return 32'(m_ss[ch] + 32 * m_si[ch]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] exp_out();
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) begin
      if (m_ap[c] == 0) r[c] = 1'b0;
      else r[c] = ((m_pos[c] < (m_ad[c] << m_as[c])) ? 1'b1 : 1'b0) ^ m_ai[c][0];
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_sp[c] <= 0; m_sd[c] <= 0; m_ss[c] <= 0; m_si[c] <= 0; m_arm[c] <= 0;
        m_ap[c] <= 0; m_ad[c] <= 0; m_as[c] <= 0; m_ai[c] <= 0; m_pos[c] <= 0;
      end
    end else begin
      int wch, wf;
      wf = bus_wr ? dec_fld(bus_addr, wch) : 0;
      for (int c = 0; c < NCH; c++) begin
        bit run, last, com, wp;
        run  = (m_ap[c] != 0);
        last = tick_1us && run && (m_pos[c] == (m_ap[c] << m_as[c]) - 1);
        com  = (m_arm[c] != 0) && (!run || last);
        wp   = (wf == 1) && (wch == c);
        if (wp) m_sp[c] <= int'(bus_wdata[CW-1:0]);
        if (wf == 2 && wch == c) m_sd[c] <= int'(bus_wdata[CW-1:0]);
        if (wf == 3 && wch == c) begin
          m_ss[c] <= int'(bus_wdata[1:0]);
          m_si[c] <= int'(bus_wdata[5]);
        end
        if (wp) m_arm[c] <= 1; else if (com) m_arm[c] <= 0;
        if (com) begin
          m_ap[c] <= m_sp[c]; m_ad[c] <= m_sd[c];
          m_as[c] <= m_ss[c]; m_ai[c] <= m_si[c];
          m_pos[c] <= 0;
        end else if (tick_1us && run) begin
          m_pos[c] <= last ? 0 : m_pos[c] + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic pick_tick();
    case (tick_mode)
      0: return 1'b1;
      1: return ($urandom % 4) != 0;
      default: return 1'b0;
    endcase
  endfunction

  // one cycle: check outputs at negedge, then drive the next inputs
  task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    chk(cur_req, 32'(pwm_out), 32'(exp_out()));
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    tick_1us = pick_tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 12'h000, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d);
    cyc(1'b0, 12'h000, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    cyc(1'b0, a, 32'h0);
    #1;
    chk(req, bus_rdata, exp_rd(a));
  endtask

  function automatic logic [11:0] a_per(input int c); return 12'(12'h400 + 4*c); endfunction
  function automatic logic [11:0] a_hi (input int c); return 12'(12'h420 + 4*c); endfunction
  function automatic logic [11:0] a_ctl(input int c); return 12'(12'h440 + 4*c); endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(pwm_out), 32'h0);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int c = 0; c < NCH; c++) begin
      rd_chk("R1", a_per(c)); rd_chk("R1", a_hi(c)); rd_chk("R1", a_ctl(c));
    end
    chk("R1", 32'(pwm_out), 32'h0);

    // R2: register layout, truncation, control field bits
    cur_req = "R2";
    wr(a_hi(1), 32'hFFFF_FF05);
    rd_chk("R2", a_hi(1));
    chk("R2", bus_rdata, 32'h05);
    wr(a_ctl(1), 32'hFFFF_FFFF);
    rd_chk("R2", a_ctl(1));
    chk("R2", bus_rdata, 32'h23);
    wr(a_ctl(1), 32'h0);
    wr(a_hi(1), 32'h2);

    // R3: unmapped offsets
    cur_req = "R3";
    wr(12'h410, 32'h7);  // channel 4
    wr(12'h401, 32'h7);  // unaligned
    wr(12'h460, 32'h7);  // beyond control group
    wr(12'h000, 32'h7);
    rd_chk("R3", 12'h410); chk("R3", bus_rdata, 32'h0);
    rd_chk("R3", 12'h401); chk("R3", bus_rdata, 32'h0);
    rd_chk("R3", 12'h460); chk("R3", bus_rdata, 32'h0);
    rd_chk("R3", a_per(0)); chk("R3", bus_rdata, 32'h0);
    idle(4);
    chk("R3", 32'(pwm_out), 32'h0);

    // R9: idle channel starts after period write
    cur_req = "R9";
    wr(a_hi(2), 32'd3);
    wr(a_per(2), 32'd6);
    chk("R9", 32'(pwm_out[2]), 32'h0);
    idle(1);
    chk("R9", 32'(pwm_out[2]), 32'h1);

    // R4: waveform, then high time at or above the period
    cur_req = "R4";
    wr(a_per(1), 32'd5);
    idle(40);
    wr(a_hi(3), 32'd9);
    wr(a_per(3), 32'd4);
    idle(3);
    for (int i = 0; i < 12; i++) begin
      idle(1);
      chk("R4", 32'(pwm_out[3]), 32'h1);
    end

    // R6: high/control writes without period write change nothing
    cur_req = "R6";
    wr(a_hi(1), 32'd4);
    wr(a_ctl(1), 32'h21);
    idle(40);

    // R7: atomic commit at the period boundary, R5 inversion
    cur_req = "R7";
    idle(2);
    wr(a_per(1), 32'd7);
    idle(60);
    cur_req = "R5";
    wr(a_ctl(2), 32'h22);
    wr(a_per(2), 32'd6);
    idle(60);

    // R8: stop with inversion set
    cur_req = "R8";
    wr(a_per(2), 32'd0);
    idle(40);
    for (int i = 0; i < 10; i++) begin
      idle(1);
      chk("R8", 32'(pwm_out[2]), 32'h0);
    end

    // R10: no ticks, outputs frozen
    cur_req = "R10";
    tick_mode = 2;
    idle(1);
    begin
      logic [NCH-1:0] held;
      idle(1);
      held = pwm_out;
      for (int i = 0; i < 20; i++) begin
        idle(1);
        chk("R10", 32'(pwm_out), 32'(held));
      end
    end

    // random mix: commits at every phase, R4 R5 R6 R7 R8 R9
    cur_req = "R7";
    tick_mode = 1;
    for (int i = 0; i < 4000; i++) begin
      if (i == 2000) tick_mode = 0;
      if (($urandom % 4) == 0) begin
        int c, k;
        logic [11:0] a;
        logic [31:0] d;
        c = $urandom % NCH;
        k = $urandom % 3;
        if (k == 0) begin
          a = a_per(c);
          d = (($urandom % 8) == 0) ? 32'd0 : 32'(1 + $urandom % 12);
        end else if (k == 1) begin
          a = a_hi(c);
          d = 32'($urandom % 14);
        end else begin
          a = a_ctl(c);
          d = $urandom;
        end
        if (($urandom % 16) == 0) a = 12'h41C;
        cyc(1'b1, a, d);
      end else if (($urandom % 8) == 0) begin
        rd_chk("R2", 12'(12'h400 + 32 * ($urandom % 3) + 4 * ($urandom % NCH)));
      end else begin
        cyc(1'b0, 12'h000, 32'h0);
      end
    end
    idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule